// File: doc/BRIEF.md
# Constant Sweep Period Controller

This block paces the scan cycles of a sequencing engine. The engine announces the end of each sweep on `sweep_done`; the block answers with a one-clock `sweep_start` pulse that launches the next sweep. With constant sweep enabled, the next start is held back until the selected period, counted in `ms_tick` pulses, has passed since the previous start. With it disabled, the next sweep is launched as soon as the previous one ends.

Two parameter sets are kept. The configured set (mode and period) is the one edited while stopped. The active set is the one that actually paces sweeps. Each time the controller goes from STOP to RUN, the configured set is copied into the active set. While running, the active set may be edited and takes effect at once, without touching the configured set. A stop followed by a new run discards those edits. Period writes outside the allowed window are refused and reported on `wr_reject`. A sweep that finishes after its period has already expired is followed by an immediate start, flagged on `overrun`.

Top module: `sweep_pacer`

## Requirements
- R1: After reset both parameter sets hold mode 0 (constant sweep off) and period 100, and `sweep_start`, `overrun` and `wr_reject` are low.
- R2: In the cycle after `run` is first sampled high following a low, `act_mode`/`act_period` equal the configured values held in the cycle before.
- R3: A `cfg_wr` (with `wr_mode` 1 meaning constant sweep on, 0 meaning off) updates `cfg_mode`/`cfg_period` on the next cycle only if `run` is low and `wr_period` lies in 5..200 inclusive; the configured values never change while `run` is high.
- R4: An `act_wr` updates `act_mode`/`act_period` on the next cycle only if `run` was high in that cycle and in the one before, and `wr_period` lies in 5..200; it leaves the configured values unchanged.
- R5: In the cycle after `run` is first sampled high, `sweep_start` pulses without waiting for any period.
- R6: With `act_mode` 1 and `act_period` P, after a start the next `sweep_start` pulses in the cycle after both hold: `sweep_done` was accepted in an earlier cycle, and P `ms_tick` pulses have been counted, counting from the cycle in which `sweep_start` was high onward.
- R7: With `act_mode` 0, `sweep_start` pulses two cycles after the cycle in which `sweep_done` is accepted, whatever `act_period` holds.
- R8: A refused write (wrong run state or period outside 5..200) raises `wr_reject` for one cycle, in the cycle after the write, and leaves the targeted set unchanged.
- R9: If `sweep_done` is accepted when at least `act_period` ticks have already been counted with `act_mode` 1, `overrun` pulses together with the following `sweep_start`; otherwise `overrun` stays low.
- R10: `sweep_start` is never high two cycles in a row, and `sweep_done` while no sweep is in progress has no effect.
- R11: While `run` is low no `sweep_start` or `overrun` is issued, and active edits made during a run are replaced by the configured set at the next run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 1 = RUN, 0 = STOP |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cfg_wr | input | 1 | Write request for the configured set |
| act_wr | input | 1 | Write request for the active set |
| wr_mode | input | 1 | Mode carried by a write (1 = constant sweep on) |
| wr_period | input | PER_W | Period in ms carried by a write |
| sweep_done | input | 1 | Engine has completed the current sweep |
| sweep_start | output | 1 | One-cycle pulse launching the next sweep |
| overrun | output | 1 | Pulses with a start that follows an overlong sweep |
| wr_reject | output | 1 | Pulses one cycle after a refused write |
| cfg_mode | output | 1 | Configured mode |
| cfg_period | output | PER_W | Configured period |
| act_mode | output | 1 | Active mode |
| act_period | output | PER_W | Active period |

## Verification
The pacing is driven with short sweeps, which separate a period-bound start from a done-bound one, and with sweeps longer than the period, which must yield immediate starts carrying `overrun`. Switching the active mode off in the middle of a run tells apart a controller that still waits on the stale period from one that restarts two cycles after each done. Writes at 4, 5, 200 and 201 and writes in the wrong run state probe the acceptance window, and a stop-then-run after active edits shows whether the configured set is recopied. Stray `sweep_done` pulses while waiting and while stopped must leave the start stream untouched.

// File: rtl/sweep_pacer_pkg.sv
package sweep_pacer_pkg;

  // inclusive window test used for every period write
  function automatic logic in_window(input int unsigned v,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // true when pacing no longer holds the next sweep back
  function automatic logic period_met(input logic mode_on,
                                      input int unsigned elapsed,
                                      input int unsigned period);
    return !mode_on || (elapsed >= period);
  endfunction

endpackage

// File: rtl/sweep_param_bank.sv
module sweep_param_bank #(
  parameter int unsigned PER_W  = 8,
  parameter int unsigned MIN_MS = 5,
  parameter int unsigned MAX_MS = 200,
  parameter int unsigned DEF_MS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_wr,
  input  logic             act_wr,
  input  logic             wr_mode,
  input  logic [PER_W-1:0] wr_period,
  output logic             run_rise,
  output logic             cfg_mode,
  output logic [PER_W-1:0] cfg_period,
  output logic             act_mode,
  output logic [PER_W-1:0] act_period,
  output logic             wr_reject
);
  import sweep_pacer_pkg::*;

  localparam logic [PER_W-1:0] DEF_P = PER_W'(DEF_MS);

  logic run_q;
  logic wr_ok;
  logic cfg_take;
  logic act_take;
  logic reject_now;

  always_comb begin
    run_rise   = run & ~run_q;
    wr_ok      = in_window(32'(wr_period), MIN_MS, MAX_MS);
    cfg_take   = cfg_wr & ~run & wr_ok;
    act_take   = act_wr & run & run_q & wr_ok;
    reject_now = (cfg_wr & ~cfg_take) | (act_wr & ~act_take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      cfg_mode   <= 1'b0;
      cfg_period <= DEF_P;
      act_mode   <= 1'b0;
      act_period <= DEF_P;
      wr_reject  <= 1'b0;
    end else begin
      run_q     <= run;
      wr_reject <= reject_now;
      if (cfg_take) begin
        cfg_mode   <= wr_mode;
        cfg_period <= wr_period;
      end
      if (run_rise) begin
        act_mode   <= cfg_mode;
        act_period <= cfg_period;
      end else if (act_take) begin
        act_mode   <= wr_mode;
        act_period <= wr_period;
      end
    end
  end

  // R2: entering RUN loads the active set from the configured set
  p_copy_on_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |=> (act_mode == $past(cfg_mode)) && (act_period == $past(cfg_period)));

  // R3: configured set frozen while running
  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(cfg_mode) && $stable(cfg_period));

  // R3/R4: stored periods stay inside the legal window
  p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_window(32'(cfg_period), MIN_MS, MAX_MS) && in_window(32'(act_period), MIN_MS, MAX_MS));

  // R8: a reject lasts one cycle unless another refused write follows
  p_reject_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $past(cfg_wr) || $past(act_wr));

endmodule

// File: rtl/sweep_ms_timer.sv
module sweep_ms_timer #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             ms_tick,
  output logic [PER_W-1:0] elapsed
);
  localparam logic [PER_W-1:0] SAT = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (!run || restart) begin
      elapsed <= '0;
    end else if (ms_tick && (elapsed != SAT)) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  // R6: a new sweep clears the count
  p_count_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (elapsed == '0));

  // R6: the count moves by at most one tick per cycle
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |=> ((elapsed - $past(elapsed)) <= PER_W'(1)));

endmodule

// File: rtl/sweep_launcher.sv
module sweep_launcher #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             run_rise,
  input  logic             sweep_done,
  input  logic             act_mode,
  input  logic [PER_W-1:0] act_period,
  input  logic [PER_W-1:0] elapsed,
  output logic             go,
  output logic             sweep_start,
  output logic             overrun
);
  import sweep_pacer_pkg::*;

  logic busy;
  logic late;
  logic ready;
  logic done_seen;

  always_comb begin
    ready     = ~busy & period_met(act_mode, 32'(elapsed), 32'(act_period));
    go        = run & (run_rise | ready);
    done_seen = sweep_done & busy & run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      late        <= 1'b0;
      sweep_start <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      sweep_start <= go;
      overrun     <= go & ~run_rise & act_mode & late;
      if (!run)           busy <= 1'b0;
      else if (go)        busy <= 1'b1;
      else if (done_seen) busy <= 1'b0;
      if (!run || go)     late <= 1'b0;
      else if (done_seen) late <= act_mode & (elapsed >= act_period);
    end
  end

  // R5: entering RUN launches a sweep at once
  p_enter_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_rise |=> sweep_start);

  // R10: start pulse is a single cycle
  p_start_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |=> !sweep_start);

  // R9: overrun only rides on a start
  p_overrun_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> sweep_start);

  // R11: nothing is launched while stopped
  p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sweep_start && !overrun);

endmodule

// File: rtl/sweep_pacer.sv
module sweep_pacer #(
  parameter int unsigned PER_W  = 8,
  parameter int unsigned MIN_MS = 5,
  parameter int unsigned MAX_MS = 200,
  parameter int unsigned DEF_MS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ms_tick,
  input  logic             cfg_wr,
  input  logic             act_wr,
  input  logic             wr_mode,
  input  logic [PER_W-1:0] wr_period,
  input  logic             sweep_done,
  output logic             sweep_start,
  output logic             overrun,
  output logic             wr_reject,
  output logic             cfg_mode,
  output logic [PER_W-1:0] cfg_period,
  output logic             act_mode,
  output logic [PER_W-1:0] act_period
);
  logic             run_rise;
  logic             go;
  logic [PER_W-1:0] elapsed;

  sweep_param_bank #(
    .PER_W(PER_W), .MIN_MS(MIN_MS), .MAX_MS(MAX_MS), .DEF_MS(DEF_MS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_wr(cfg_wr), .act_wr(act_wr), .wr_mode(wr_mode), .wr_period(wr_period),
    .run_rise(run_rise),
    .cfg_mode(cfg_mode), .cfg_period(cfg_period),
    .act_mode(act_mode), .act_period(act_period),
    .wr_reject(wr_reject)
  );

  sweep_ms_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(go),
    .ms_tick(ms_tick), .elapsed(elapsed)
  );

  sweep_launcher #(.PER_W(PER_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .run(run), .run_rise(run_rise),
    .sweep_done(sweep_done), .act_mode(act_mode), .act_period(act_period),
    .elapsed(elapsed), .go(go), .sweep_start(sweep_start), .overrun(overrun)
  );

endmodule

// File: tb/sweep_pacer_test.sv
`timescale 1ns/100ps
module sweep_pacer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       ms_tick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       act_wr = 1'b0;
  logic       wr_mode = 1'b0;
  logic [7:0] wr_period = 8'd0;
  logic       sweep_done;
  logic       sweep_start, overrun, wr_reject, cfg_mode, act_mode;
  logic [7:0] cfg_period, act_period;

  logic eng_done = 1'b0;
  logic stray_done = 1'b0;
  assign sweep_done = eng_done | stray_done;

  int n_chk = 0;
  int n_fail = 0;
  int work_len = 5;
  int eng_cnt = 0;
  int tick_div = 0;
  int n_starts = 0;
  int n_ovr = 0;

  always #2.5 clk = ~clk;

  sweep_pacer uut (
    .clk(clk), .rst_n(rst_n), .run(run), .ms_tick(ms_tick),
    .cfg_wr(cfg_wr), .act_wr(act_wr), .wr_mode(wr_mode), .wr_period(wr_period),
    .sweep_done(sweep_done), .sweep_start(sweep_start), .overrun(overrun),
    .wr_reject(wr_reject), .cfg_mode(cfg_mode), .cfg_period(cfg_period),
    .act_mode(act_mode), .act_period(act_period)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // millisecond tick every third cycle, and a sweep engine of work_len cycles
  always @(negedge clk) begin
    tick_div = (tick_div == 2) ? 0 : tick_div + 1;
    ms_tick  = (tick_div == 0);
    eng_done = 1'b0;
    if (sweep_start) begin
      n_starts++;
      if (overrun) n_ovr++;
      eng_cnt = work_len;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) eng_done = 1'b1;
    end
  end

  // behavioural reference: sweep phase tracked as "running" or "waiting"
  bit m_was_run, m_cm, m_am, m_running, m_slow;
  int m_cp = 100, m_ap = 100, m_ms = 0;
  bit e_start, e_ovr, e_rej;

  always @(posedge clk) begin : model
    bit entering, launch, legal, finished;
    if (!rst_n) begin
      m_was_run = 0; m_cm = 0; m_am = 0; m_cp = 100; m_ap = 100;
      m_running = 0; m_slow = 0; m_ms = 0;
      e_start = 0; e_ovr = 0; e_rej = 0;
    end else begin
      entering = run && !m_was_run;
      legal    = (wr_period >= 5) && (wr_period <= 200);
      launch   = 0;
      if (run) begin
        if (entering) launch = 1;
        else if (!m_running && (m_am == 0 || m_ms >= m_ap)) launch = 1;
      end
      finished = run && m_running && sweep_done;
      e_start = launch;
      e_ovr   = launch && !entering && m_am && m_slow;
      e_rej   = 0;
      if (cfg_wr && (run || !legal)) e_rej = 1;
      if (act_wr && (!run || !m_was_run || !legal)) e_rej = 1;
      if (entering) begin
        m_am = m_cm; m_ap = m_cp;
      end else if (act_wr && run && m_was_run && legal) begin
        m_am = wr_mode; m_ap = wr_period;
      end
      if (cfg_wr && !run && legal) begin
        m_cm = wr_mode; m_cp = wr_period;
      end
      if (!run || launch) m_slow = 0;
      else if (finished) m_slow = (e_start == 0) && m_am_old_ok(m_ms);
      if (!run) m_running = 0;
      else if (launch) m_running = 1;
      else if (finished) m_running = 0;
      if (!run || launch) m_ms = 0;
      else if (ms_tick && m_ms < 255) m_ms++;
      m_was_run = run;
    end
  end

  // lateness judged against the active set as it stood before this edge
  bit prev_am; int prev_ap;
  always @(negedge clk) begin prev_am = act_mode; prev_ap = act_period; end
  function automatic bit m_am_old_ok(input int ms);
    return prev_am && (ms >= prev_ap);
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 R6 R7 R10", "sweep_start", sweep_start, e_start);
      chk("R9", "overrun", overrun, e_ovr);
      chk("R8", "wr_reject", wr_reject, e_rej);
      chk("R3", "cfg_period", cfg_period, m_cp);
      chk("R4", "act_period", act_period, m_ap);
      chk("R4", "act_mode", act_mode, m_am);
    end
  end

  task automatic do_wr(input bit to_act, input bit mode, input int per, output bit rej);
    @(negedge clk); #1;
    cfg_wr = !to_act; act_wr = to_act; wr_mode = mode; wr_period = 8'(per);
    @(negedge clk);
    rej = wr_reject;
    #1 cfg_wr = 0; act_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : main
    bit r;
    int s0;
    idle(3);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "cfg_mode", cfg_mode, 0);
    chk("R1", "cfg_period", cfg_period, 100);
    chk("R1", "act_period", act_period, 100);
    chk("R1", "sweep_start", sweep_start, 0);

    do_wr(0, 1, 4, r);   chk("R8", "reject 4", r, 1); chk("R8", "cfg kept", cfg_period, 100);
    do_wr(0, 1, 201, r); chk("R8", "reject 201", r, 1);
    do_wr(0, 1, 200, r); chk("R3", "accept 200", r, 0); chk("R3", "cfg 200", cfg_period, 200);
    do_wr(0, 1, 5, r);   chk("R3", "accept 5", r, 0);
    do_wr(0, 1, 8, r);   chk("R3", "cfg_mode", cfg_mode, 1);
    do_wr(1, 0, 50, r);  chk("R4", "act in stop", r, 1); chk("R4", "act kept", act_period, 100);

    #1 run = 1;
    @(negedge clk);
    chk("R5", "first start", sweep_start, 1);
    chk("R2", "act_mode copied", act_mode, 1);
    chk("R2", "act_period copied", act_period, 8);
    idle(150);

    work_len = 40; n_ovr = 0;
    idle(200);
    chk("R9", "overruns seen", int'(n_ovr > 0), 1);
    work_len = 5;
    idle(80); n_ovr = 0;
    idle(100);
    chk("R9", "no overrun on short sweeps", n_ovr, 0);

    do_wr(0, 0, 50, r); chk("R3", "cfg in run", r, 1); chk("R3", "cfg unchanged", cfg_period, 8);
    do_wr(1, 1, 20, r); chk("R4", "act in run", r, 0);
    chk("R4", "act 20", act_period, 20); chk("R4", "cfg still 8", cfg_period, 8);
    idle(200);
    do_wr(1, 1, 3, r); chk("R8", "act reject 3", r, 1); chk("R8", "act kept 20", act_period, 20);

    do_wr(1, 0, 20, r);
    idle(30);
    s0 = n_starts;
    idle(70);
    chk("R7", "fast starts in 70 cycles", int'((n_starts - s0) >= 9), 1);

    do_wr(1, 1, 200, r);
    idle(40);
    s0 = n_starts;
    #1 stray_done = 1; @(negedge clk); #1 stray_done = 0;
    idle(20);
    chk("R10", "stray done ignored", n_starts - s0, 0);

    #1 run = 0;
    idle(3);
    s0 = n_starts;
    #1 stray_done = 1; @(negedge clk); #1 stray_done = 0;
    idle(20);
    chk("R11", "no starts in stop", n_starts - s0, 0);
    #1 run = 1;
    @(negedge clk);
    chk("R11", "act recopied mode", act_mode, 1);
    chk("R11", "act recopied period", act_period, 8);
    idle(60);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule